// File: doc/BRIEF.md
# Burst-Capable Synchronous Static Memory with Flow-Through Read

A clocked single-port memory of 36-bit words, each split into four 9-bit byte lanes. An access starts when either of two active-low address strobes is seen at a rising edge. One strobe is meant for a processor and one for a cache controller. The captured address is then extended by an internal two-bit step counter. This counter walks through a group of four words, either in linear order or in interleaved order, for as long as the active-low step input is held low. Read data is not registered: the word at the current address reaches `data_o` in the same cycle in which that address became current.

A write is decided at the end of its cycle, at the rising edge that closes it. It goes to the current address. A global write strobe writes all four lanes. Otherwise, a lane write enable combined with four lane selects picks individual lanes. Three chip enables, an output enable and a sleep input deselect or quiet the device. The data bus is modelled as a separate input, output and output-enable. A released bus reads as `data_oe_o = 0` with `data_o = 0`.

Top module: `burst_sram`

## Requirements
- R1: At a rising edge where a strobe is accepted and `ce_ni=0`, `cs_i=1` and `cs_ni=0`, `addr_i` is captured and becomes the current address, and the step count returns to 0.
- R2: Read data is flow-through: right after the loading or stepping edge, `data_o` carries the stored word at the current address with `data_oe_o=1`, with no extra cycle of latency.
- R3: The step count advances by one (modulo 4) only at edges where `step_ni=0` and no strobe is accepted. With `step_ni=1` the current address holds.
- R4: With `order_i=1` (linear), the low two address bits are (loaded low bits + step) mod 4. The upper bits stay fixed.
- R5: With `order_i=0` (interleaved), the low two address bits are (loaded low bits) XOR step. The upper bits stay fixed.
- R6: `all_wr_ni=0` at an edge writes all four lanes of `data_i` to the current address.
- R7: With `all_wr_ni=1` and `lane_wr_en_ni=0`, lane i (bits 9i+8..9i) is written exactly when `lane_sel_ni[i]=0`. With `lane_wr_en_ni=1`, the cycle is a read and the stored word is unchanged.
- R8: `proc_strobe_ni=0` is ignored while `ce_ni=1`, and the current address and data stay unchanged. `ctrl_strobe_ni=0` is always accepted and samples all chip enables.
- R9: An accepted strobe with any chip enable inactive deselects the device from the next cycle: `data_oe_o=0`, and writes are blocked until a strobe with all enables active.
- R10: While `sleep_i=1`, `data_oe_o=0` in the same cycle and writes are blocked. The contents are retained. After wake-up, the output stays released until a new enabled strobe.
- R11: `oe_ni=1` releases the output combinationally (`data_oe_o=0`, `data_o=0`).
- R12: After reset, the device is deselected and `data_oe_o=0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Word address |
| proc_strobe_ni | input | 1 | Processor address strobe, active low, gated by ce_ni |
| ctrl_strobe_ni | input | 1 | Controller address strobe, active low |
| step_ni | input | 1 | Burst advance, active low |
| order_i | input | 1 | 1 linear order, 0 interleaved order |
| ce_ni | input | 1 | Primary chip enable, active low |
| cs_i | input | 1 | Chip select, active high |
| cs_ni | input | 1 | Chip select, active low |
| oe_ni | input | 1 | Output enable, active low |
| all_wr_ni | input | 1 | Global write, all lanes, active low |
| lane_wr_en_ni | input | 1 | Lane write enable, active low |
| lane_sel_ni | input | LANES | Per-lane write select, active low |
| sleep_i | input | 1 | Sleep, active high |
| data_i | input | LANES*LANE_W | Write data |
| data_o | output | LANES*LANE_W | Flow-through read data, 0 when released |
| data_oe_o | output | 1 | Output drive enable |

## Verification
The hardest point to reach from the ports is a step count that is not aligned with the loaded address. In that case the two orders diverge, and the wrap from step 3 back to 0 must land on the right word. The bench first fills every word through write bursts with arithmetic patterns. It then loads every address of the array in both orders and reads all four words of each burst. This covers every low-bit start offset against every step value. The interactions of strobes with chip enables, sleep and the lane masks are then driven as short scripted sequences around this sweep. Each is followed by a fresh load that reads back the affected word.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  localparam int unsigned STEP_W = 2;

  // low two address bits for a given burst step
  function automatic logic [STEP_W-1:0] burst_low(
    input logic [STEP_W-1:0] base,
    input logic [STEP_W-1:0] idx,
    input logic              linear
  );
    return linear ? STEP_W'(base + idx) : (base ^ idx);
  endfunction
endpackage

// File: rtl/burst_seq.sv
module burst_seq
  import burst_sram_pkg::*;
#(
  parameter int unsigned AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          proc_strobe_ni,
  input  logic          ctrl_strobe_ni,
  input  logic          step_ni,
  input  logic          order_i,
  input  logic          ce_ni,
  input  logic          cs_i,
  input  logic          cs_ni,
  input  logic          sleep_i,
  output logic [AW-1:0] cur_addr_o,
  output logic [STEP_W-1:0] idx_o,
  output logic          active_o
);
  logic [AW-1:0]     base_q;
  logic [STEP_W-1:0] idx_q;
  logic              active_q;
  logic              go, en;

  assign go = (!proc_strobe_ni && !ce_ni) || !ctrl_strobe_ni;
  assign en = !ce_ni && cs_i && !cs_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q   <= '0;
      idx_q    <= '0;
      active_q <= 1'b0;
    end else if (sleep_i) begin
      active_q <= 1'b0;
    end else if (go) begin
      active_q <= en;
      if (en) begin
        base_q <= addr_i;
        idx_q  <= '0;
      end
    end else if (active_q && !step_ni) begin
      idx_q <= idx_q + STEP_W'(1);
    end
  end

  assign cur_addr_o = {base_q[AW-1:STEP_W], burst_low(base_q[STEP_W-1:0], idx_q, order_i)};
  assign idx_o      = idx_q;
  assign active_o   = active_q;
endmodule

// File: rtl/lane_write_dec.sv
module lane_write_dec #(
  parameter int unsigned LANES = 4
) (
  input  logic             all_wr_ni,
  input  logic             lane_wr_en_ni,
  input  logic [LANES-1:0] lane_sel_ni,
  input  logic             allow_i,
  output logic [LANES-1:0] lane_we_o
);
  logic [LANES-1:0] req;
  always_comb begin
    if (!all_wr_ni)          req = '1;
    else if (!lane_wr_en_ni) req = ~lane_sel_ni;
    else                     req = '0;
    lane_we_o = allow_i ? req : '0;
  end
endmodule

// File: rtl/sram_lane.sv
module sram_lane #(
  parameter int unsigned AW     = 10,
  parameter int unsigned LANE_W = 9
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [LANE_W-1:0] wdata_i,
  output logic [LANE_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;
  logic [LANE_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int unsigned AW     = 10,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [AW-1:0]           addr_i,
  input  logic                    proc_strobe_ni,
  input  logic                    ctrl_strobe_ni,
  input  logic                    step_ni,
  input  logic                    order_i,
  input  logic                    ce_ni,
  input  logic                    cs_i,
  input  logic                    cs_ni,
  input  logic                    oe_ni,
  input  logic                    all_wr_ni,
  input  logic                    lane_wr_en_ni,
  input  logic [LANES-1:0]        lane_sel_ni,
  input  logic                    sleep_i,
  input  logic [LANES*LANE_W-1:0] data_i,
  output logic [LANES*LANE_W-1:0] data_o,
  output logic                    data_oe_o
);
  localparam int unsigned DW = LANES * LANE_W;

  logic [AW-1:0]     cur_addr;
  logic [STEP_W-1:0] idx;
  logic              active;
  logic [LANES-1:0]  lane_we;
  logic [DW-1:0]     rd_word;

  burst_seq #(.AW(AW)) u_seq (
    .clk_i, .rst_ni, .addr_i, .proc_strobe_ni, .ctrl_strobe_ni, .step_ni,
    .order_i, .ce_ni, .cs_i, .cs_ni, .sleep_i,
    .cur_addr_o(cur_addr), .idx_o(idx), .active_o(active)
  );

  lane_write_dec #(.LANES(LANES)) u_dec (
    .all_wr_ni, .lane_wr_en_ni, .lane_sel_ni,
    .allow_i(active && !sleep_i),
    .lane_we_o(lane_we)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sram_lane #(.AW(AW), .LANE_W(LANE_W)) u_lane (
      .clk_i,
      .we_i   (lane_we[g]),
      .addr_i (cur_addr),
      .wdata_i(data_i[g*LANE_W +: LANE_W]),
      .rdata_o(rd_word[g*LANE_W +: LANE_W])
    );
  end

  assign data_oe_o = active && !oe_ni && !sleep_i;
  assign data_o    = data_oe_o ? rd_word : '0;
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
  parameter int unsigned AW = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] addr_i,
  input logic          proc_strobe_ni,
  input logic          ctrl_strobe_ni,
  input logic          step_ni,
  input logic          ce_ni,
  input logic          cs_i,
  input logic          cs_ni,
  input logic          sleep_i,
  input logic          data_oe_o,
  input logic [AW-1:0] cur_addr,
  input logic [1:0]    idx,
  input logic          active
);
  logic go, en;
  assign go = (!proc_strobe_ni && !ce_ni) || !ctrl_strobe_ni;
  assign en = !ce_ni && cs_i && !cs_ni;

  AST_LOAD_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && go && en) |=> (cur_addr[AW-1:2] == $past(addr_i[AW-1:2]) && idx == 2'd0)); // R1
  AST_STEP_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && !go && active && !step_ni) |=> idx == $past(idx) + 2'd1); // R3
  AST_STEP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && !go && step_ni) |=> $stable(idx)); // R3
  AST_PROC_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && ce_ni && ctrl_strobe_ni && step_ni) |=> ($stable(idx) && $stable(active))); // R8
  AST_DESELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && !en) |=> !data_oe_o); // R9
  AST_SLEEP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> !data_oe_o); // R10
  AST_WAKE_NEEDS_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> !active); // R10
endmodule

bind burst_sram burst_sram_chk #(.AW(AW)) u_chk (
  .clk_i, .rst_ni, .addr_i, .proc_strobe_ni, .ctrl_strobe_ni, .step_ni,
  .ce_ni, .cs_i, .cs_ni, .sleep_i, .data_oe_o,
  .cur_addr(cur_addr), .idx(idx), .active(active)
);

// File: tb/burst_sram_test.sv
module burst_sram_test;
  localparam int AW = 10, DEPTH = 1 << AW, DW = 36;

  logic clk = 0, rst_ni = 0;
  logic [AW-1:0] addr = '0;
  logic proc_n = 1, ctrl_n = 1, step_n = 1, order = 1;
  logic ce_n = 0, cs = 1, cs_n = 0, oe_n = 0, all_wr_n = 1, lane_en_n = 1, sleep = 0;
  logic [3:0] sel_n = '1;
  logic [DW-1:0] din = '0, dout;
  logic doe;
  logic [DW-1:0] exp_mem [DEPTH];
  int n_cmp = 0, n_bad = 0;

  always #5 clk = ~clk;

  burst_sram uut (
    .clk_i(clk), .rst_ni, .addr_i(addr), .proc_strobe_ni(proc_n), .ctrl_strobe_ni(ctrl_n),
    .step_ni(step_n), .order_i(order), .ce_ni(ce_n), .cs_i(cs), .cs_ni(cs_n), .oe_ni(oe_n),
    .all_wr_ni(all_wr_n), .lane_wr_en_ni(lane_en_n), .lane_sel_ni(sel_n), .sleep_i(sleep),
    .data_i(din), .data_o(dout), .data_oe_o(doe)
  );

  task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    logic [DW-1:0] v = DW'(a) * 36'd2654435 + DW'(salt) * 36'd977 + 36'h1;
    return v ^ {v[17:0], v[35:18]};
  endfunction

  function automatic int seq(input int a, input int k, input bit lin);
    int lo = lin ? (((a & 3) + k) & 3) : ((a & 3) ^ k);
    return (a & ~3) | lo;
  endfunction

  task automatic tick(); @(negedge clk); endtask

  task automatic idle();
    proc_n = 1; ctrl_n = 1; step_n = 1; all_wr_n = 1; lane_en_n = 1; sel_n = '1;
    ce_n = 0; cs = 1; cs_n = 0; oe_n = 0; sleep = 0;
  endtask

  task automatic load(input int a, input bit use_proc);
    addr = AW'(a);
    if (use_proc) proc_n = 0; else ctrl_n = 0;
    tick();
    proc_n = 1; ctrl_n = 1;
  endtask

  task automatic write_burst(input int a, input bit lin, input int salt);
    order = lin;
    load(a, 0);
    for (int k = 0; k < 4; k++) begin
      int w = seq(a, k, lin);
      all_wr_n = 0; step_n = 0; din = pat(w, salt);
      tick();
      exp_mem[w] = pat(w, salt);
    end
    idle();
  endtask

  task automatic read_burst(input int a, input bit lin);
    order = lin;
    load(a, 0);
    for (int k = 0; k < 4; k++) begin
      int w = seq(a, k, lin);
      chk(DW'(doe), 36'd1, lin ? "R2 oe lin" : "R2 oe ilv");
      chk(dout, exp_mem[w], lin ? "R1 R4 linear word" : "R1 R5 interleaved word");
      step_n = 0;
      tick();
    end
    step_n = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle();
    tick();
    chk(DW'(doe), 36'd0, "R12 reset released");
    rst_ni = 1;
    tick();

    // R6: fill every word with global writes, alternating orders and start offsets
    for (int b = 0; b < DEPTH; b += 4) write_burst(b + ((b >> 2) & 3), (b >> 2) % 2 == 0, 1);

    // R4 R5: every start address, both orders
    for (int a = 0; a < DEPTH; a++) begin
      read_burst(a, 1);
      read_burst(a, 0);
    end

    // R3: hold while step_ni high, then advance
    order = 1;
    load(37, 0);
    tick(); chk(dout, exp_mem[37], "R3 hold 1");
    tick(); chk(dout, exp_mem[37], "R3 hold 2");
    step_n = 0; tick(); step_n = 1;
    chk(dout, exp_mem[38], "R3 advance");

    // R7: every lane mask
    for (int m = 0; m < 16; m++) begin
      int a = 100 + m;
      logic [DW-1:0] nv = pat(a, 9);
      load(a, 0);
      all_wr_n = 1; lane_en_n = 0; sel_n = ~4'(m); din = nv;
      tick(); idle();
      for (int l = 0; l < 4; l++)
        if (m[l]) exp_mem[a][l*9 +: 9] = nv[l*9 +: 9];
      load(a, 0);
      chk(dout, exp_mem[a], "R7 lane mask");
    end
    load(200, 0);
    lane_en_n = 1; sel_n = '0; din = pat(200, 33);
    tick(); idle();
    load(200, 0);
    chk(dout, exp_mem[200], "R7 no lane enable no write");

    // R8: processor strobe gated by ce_ni
    load(300, 0);
    ce_n = 1; addr = 10'd400; proc_n = 0;
    tick(); proc_n = 1; ce_n = 0;
    chk(dout, exp_mem[300], "R8 proc strobe ignored");
    load(400, 1);
    chk(dout, exp_mem[400], "R8 proc strobe loads");

    // R9: controller strobe with cs_i low deselects, writes blocked
    cs = 0;
    load(500, 0);
    chk(DW'(doe), 36'd0, "R9 deselected");
    cs = 1; all_wr_n = 0; din = pat(0, 77);
    tick(); idle();
    chk(DW'(doe), 36'd0, "R9 still deselected");
    load(400, 0);
    chk(dout, exp_mem[400], "R9 write blocked");
    load(500, 0);
    chk(dout, exp_mem[500], "R9 target unchanged");

    // R10: sleep
    load(600, 0);
    sleep = 1; #1;
    chk(DW'(doe), 36'd0, "R10 sleep releases");
    all_wr_n = 0; din = pat(0, 55);
    tick(); idle();
    tick();
    chk(DW'(doe), 36'd0, "R10 needs strobe after wake");
    load(600, 0);
    chk(dout, exp_mem[600], "R10 contents retained");

    // R11: output enable
    oe_n = 1; #1;
    chk(DW'(doe), 36'd0, "R11 oe released");
    chk(dout, 36'd0, "R11 data zero");
    oe_n = 0; #1;
    chk(dout, exp_mem[600], "R11 oe restored");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule